// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

A memory-mapped general-purpose I/O block serving up to 32 pins over a plain 32-bit register bus. Bus addresses are byte offsets and every register is one word wide. Bit N of every register belongs to pin N. Software decides per pin whether the input is sampled and whether the pin is driven. It also sets the value to drive and an inversion mask that is XORed onto that value on its way to the pad.

Pin inputs are resynchronized. The synchronized value is watched for four trigger kinds: rising edge, falling edge, high level and low level. Each kind has its own enable register and its own sticky pending register. A pending bit is cleared by writing a one to it. Each pin owns a separate interrupt line toward the interrupt controller. That line is high while any pending bit of the pin is set together with the matching enable bit.

Bus writes take effect on the clock edge while `bus_wr` is high. Reads are combinational from the addressed register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads zero, `pin_oe` is zero and `irq` is zero.
- R2: Register offsets are fixed as follows, and each is read/write unless stated otherwise:
  - 0x00: input level, read-only.
  - 0x04: input enable.
  - 0x08: drive enable.
  - 0x0C: drive value.
  - 0x40: inversion mask.
  - 0x18, 0x20, 0x28, 0x30: enables for rise, fall, high and low.
  - 0x1C, 0x24, 0x2C, 0x34: pending for rise, fall, high and low.
  
  Register bits at or above NUM_PINS read zero, and writes to them are dropped.
- R3: A read at 0x0C returns the stored drive value, not the level seen on the pin.
- R4: `pin_out` equals the drive value XOR the inversion mask. `pin_oe` equals the drive enable register.
- R5: Input level at 0x00 is the pin input after two synchronizing flops, ANDed with input enable. A change on `pin_in` is visible after the second clock edge.
- R6: A rise pending bit sets on the edge after the synchronized input goes from 0 to 1. A fall pending bit sets on the edge after it goes from 1 to 0. Both are three clock edges after `pin_in` changes.
- R7: A high pending bit sets on every edge where the synchronized input is 1, and a low pending bit sets on every edge where it is 0. After a clear, a level bit sets again on the next edge while its level persists.
- R8: Pending bits are sticky. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A clear wins over a set in the same cycle.
- R9: Pending bits set whether or not the matching enable is set.
- R10: `irq[n]` is high exactly when, for some trigger kind, both the pending bit n and the enable bit n are set.
- R11: Writes to unmapped offsets and to the input level register change nothing. Reads from unmapped offsets return zero.
- R12: With all four enable registers zero, every `irq` line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | NUM_PINS | Raw pad inputs |
| pin_out | output | NUM_PINS | Value to drive on the pads |
| pin_oe | output | NUM_PINS | Pad drive enable; low means tristated |
| irq | output | NUM_PINS | One interrupt line per pin |

## Verification
The bench builds the controller with NUM_PINS = 12, leaving 20 unused bits in each register. This exercises both the masking of wide writes and the zero upper bits on reads. It also covers every pin in one short random stretch. A behavioural model tracks the synchronizer, the previous-cycle value and all pending registers. Against it, the bench compares the drive outputs, the interrupt lines and the read data of the currently addressed register every cycle. Directed steps pin down the exact clock edge at which input levels, edge pendings and the re-set of a cleared level pending appear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_kind_e;

  localparam int NUM_KINDS = 4;

  localparam logic [7:0] OFS_LEVEL     = 8'h00;
  localparam logic [7:0] OFS_SENSE_EN  = 8'h04;
  localparam logic [7:0] OFS_DRIVE_EN  = 8'h08;
  localparam logic [7:0] OFS_DRIVE_VAL = 8'h0C;
  localparam logic [7:0] OFS_INVERT    = 8'h40;
  localparam logic [7:0] OFS_TRIG_BASE = 8'h18;

  // enable register of trigger kind k; pending sits one word above
  function automatic logic [7:0] trig_en_ofs(int k);
    return OFS_TRIG_BASE + 8'(k * 8);
  endfunction

  function automatic logic [7:0] trig_pend_ofs(int k);
    return OFS_TRIG_BASE + 8'(k * 8 + 4);
  endfunction

  // condition of one trigger kind from current and previous synced level
  function automatic logic trig_cond(trig_kind_e kind, logic cur, logic prv);
    case (kind)
      TRIG_RISE: return cur & ~prv;
      TRIG_FALL: return ~cur & prv;
      TRIG_HIGH: return cur;
      default:   return ~cur;
    endcase
  endfunction

  // one pin's interrupt: any kind both pending and enabled
  function automatic logic pin_irq(logic [NUM_KINDS-1:0] pend,
                                   logic [NUM_KINDS-1:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] cur,
  output logic [NUM_PINS-1:0] prv
);

  logic [STAGES-1:0][NUM_PINS-1:0] stage_q;
  logic [NUM_PINS-1:0]             prv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= stage_q[STAGES-1];
  end

  assign cur = stage_q[STAGES-1];
  assign prv = prv_q;

endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
  import gpio_irq_pkg::*;
#(
  parameter int         NUM_PINS = 32,
  parameter trig_kind_e KIND     = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cur,
  input  logic [NUM_PINS-1:0] prv,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] hit,
  output logic [NUM_PINS-1:0] pend
);

  logic [NUM_PINS-1:0] pend_q;

  always_comb begin
    for (int n = 0; n < NUM_PINS; n++) hit[n] = trig_cond(KIND, cur[n], prv[n]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | hit) & ~clr;
  end

  assign pend = pend_q;

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr)) == '0));

  // R6
  cond_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~$past(clr) & ~pend) == '0));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic                                 bus_wr,
  input  logic [31:0]                          bus_wdata,
  output logic [31:0]                          bus_rdata,
  input  logic [NUM_PINS-1:0]                  level,
  input  logic [NUM_KINDS-1:0][NUM_PINS-1:0]   pend,
  output logic [NUM_PINS-1:0]                  sense_en,
  output logic [NUM_PINS-1:0]                  drive_en,
  output logic [NUM_PINS-1:0]                  drive_val,
  output logic [NUM_PINS-1:0]                  invert,
  output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   trig_en,
  output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   clr
);

  logic [NUM_PINS-1:0] wd;
  assign wd = bus_wdata[NUM_PINS-1:0];

  function automatic logic hit_at(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_en  <= '0;
      drive_en  <= '0;
      drive_val <= '0;
      invert    <= '0;
    end else if (bus_wr) begin
      if (hit_at(bus_addr, OFS_SENSE_EN))  sense_en  <= wd;
      if (hit_at(bus_addr, OFS_DRIVE_EN))  drive_en  <= wd;
      if (hit_at(bus_addr, OFS_DRIVE_VAL)) drive_val <= wd;
      if (hit_at(bus_addr, OFS_INVERT))    invert    <= wd;
    end
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    always_ff @(posedge clk) begin
      if (!rst_n)                                       trig_en[k] <= '0;
      else if (bus_wr && hit_at(bus_addr, trig_en_ofs(k))) trig_en[k] <= wd;
    end
    assign clr[k] = (bus_wr && hit_at(bus_addr, trig_pend_ofs(k))) ? wd : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_at(bus_addr, OFS_LEVEL))     bus_rdata = 32'(level & sense_en);
    if (hit_at(bus_addr, OFS_SENSE_EN))  bus_rdata = 32'(sense_en);
    if (hit_at(bus_addr, OFS_DRIVE_EN))  bus_rdata = 32'(drive_en);
    if (hit_at(bus_addr, OFS_DRIVE_VAL)) bus_rdata = 32'(drive_val);
    if (hit_at(bus_addr, OFS_INVERT))    bus_rdata = 32'(invert);
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (hit_at(bus_addr, trig_en_ofs(k)))   bus_rdata = 32'(trig_en[k]);
      if (hit_at(bus_addr, trig_pend_ofs(k))) bus_rdata = 32'(pend[k]);
    end
  end

  // R11
  level_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_at(bus_addr, OFS_LEVEL)) |=>
      ($stable(sense_en) && $stable(drive_en) && $stable(drive_val) && $stable(invert)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] irq
);

  logic [NUM_PINS-1:0]                cur, prv;
  logic [NUM_PINS-1:0]                sense_en, drive_en, drive_val, invert;
  logic [NUM_KINDS-1:0][NUM_PINS-1:0] trig_en, clr, pend, hit;

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prv(prv)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
    gpio_trig_bank #(.NUM_PINS(NUM_PINS), .KIND(trig_kind_e'(k))) u_bank (
      .clk(clk), .rst_n(rst_n), .cur(cur), .prv(prv),
      .clr(clr[k]), .hit(hit[k]), .pend(pend[k])
    );
  end

  gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level(cur), .pend(pend),
    .sense_en(sense_en), .drive_en(drive_en), .drive_val(drive_val), .invert(invert),
    .trig_en(trig_en), .clr(clr)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [NUM_KINDS-1:0] p_bits, e_bits;
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
      assign p_bits[k] = pend[k][n];
      assign e_bits[k] = trig_en[k][n];
    end
    assign irq[n] = pin_irq(p_bits, e_bits);
  end

  assign pin_out = drive_val ^ invert;
  assign pin_oe  = drive_en;

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~(trig_en[0] | trig_en[1] | trig_en[2] | trig_en[3])) == '0);

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en == '0) |-> (irq == '0));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int N = 12;
  localparam logic [N-1:0] MASK = '1;

  logic          clk = 0, rst_n = 0;
  logic [7:0]    addr = 0;
  logic          wr = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata;
  logic [N-1:0]  pin_in = 0, pin_out, pin_oe, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(8), .SYNC_STAGES(2)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference
  logic [N-1:0] m_sense, m_den, m_dval, m_inv, m_s1, m_s2, m_prev;
  logic [N-1:0] m_en[4], m_pend[4], m_cond[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sense = 0; m_den = 0; m_dval = 0; m_inv = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      for (int k = 0; k < 4; k++) begin m_en[k] = 0; m_pend[k] = 0; end
    end else begin
      m_cond[0] = m_s2 & ~m_prev;
      m_cond[1] = m_prev & ~m_s2;
      m_cond[2] = m_s2;
      m_cond[3] = ~m_s2;
      for (int k = 0; k < 4; k++) begin
        logic [N-1:0] c;
        c = (wr && addr == 8'(8'h1C + 8 * k)) ? wdata[N-1:0] : '0;
        m_pend[k] = (m_pend[k] | m_cond[k]) & ~c;
        if (wr && addr == 8'(8'h18 + 8 * k)) m_en[k] = wdata[N-1:0];
      end
      if (wr) begin
        if (addr == 8'h04) m_sense = wdata[N-1:0];
        if (addr == 8'h08) m_den   = wdata[N-1:0];
        if (addr == 8'h0C) m_dval  = wdata[N-1:0];
        if (addr == 8'h40) m_inv   = wdata[N-1:0];
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return 32'(m_s2 & m_sense);
      8'h04: return 32'(m_sense);
      8'h08: return 32'(m_den);
      8'h0C: return 32'(m_dval);
      8'h40: return 32'(m_inv);
      8'h18: return 32'(m_en[0]); 8'h1C: return 32'(m_pend[0]);
      8'h20: return 32'(m_en[1]); 8'h24: return 32'(m_pend[1]);
      8'h28: return 32'(m_en[2]); 8'h2C: return 32'(m_pend[2]);
      8'h30: return 32'(m_en[3]); 8'h34: return 32'(m_pend[3]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [N-1:0] m_irq();
    logic [N-1:0] r = '0;
    for (int k = 0; k < 4; k++) r |= m_pend[k] & m_en[k];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 pin_out", 32'(pin_out), 32'(m_dval ^ m_inv));
      check("R4 pin_oe", 32'(pin_oe), 32'(m_den));
      check("R10 irq", 32'(irq), 32'(m_irq()));
      check("R2 rdata", rdata, m_read(addr));
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #2;
    addr = a; wdata = d; wr = 1;
    @(negedge clk); #2;
    wr = 0;
  endtask

  task automatic read_check(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    check(tag, rdata, exp);
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk); #2;
    pin_in = v;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 'h48; a += 4) read_check(8'(a), 32'h0, "R1 reset read");
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    @(negedge clk); #2;
    rst_n = 1;

    // R9 low pending sets with enable off; R12 lines stay low
    step(1);
    read_check(8'h34, 32'hFFF, "R9 low pending without enable");
    check("R12 irq with enables off", 32'(irq), 32'h0);

    // R8 clear wins, R7 level re-sets
    bus_write(8'h34, 32'hFFF);
    read_check(8'h34, 32'h0, "R8 clear wins over level");
    step(1);
    read_check(8'h34, 32'hFFF, "R7 level pending re-sets");
    bus_write(8'h34, 32'h0);
    read_check(8'h34, 32'hFFF, "R8 write zero keeps");

    // R2 R3 R4 outputs
    bus_write(8'h0C, 32'hFFFF_FA5A);
    bus_write(8'h40, 32'h0F0);
    bus_write(8'h08, 32'h00F);
    read_check(8'h0C, 32'hA5A, "R2 upper bits dropped");
    read_check(8'h0C, 32'hA5A, "R3 drive value readback");
    check("R4 inverted output", 32'(pin_out), 32'hAAA);
    check("R4 output enable", 32'(pin_oe), 32'h00F);

    // R11 unmapped and read-only offsets
    bus_write(8'h44, 32'hFFFF_FFFF);
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h00, 32'hFFFF_FFFF);
    read_check(8'h44, 32'h0, "R11 unmapped read");
    read_check(8'h10, 32'h0, "R11 unmapped read");
    read_check(8'h04, 32'h0, "R11 write to level ignored");
    read_check(8'h0C, 32'hA5A, "R11 drive value untouched");

    // R5 synchronizer latency and input gating
    bus_write(8'h04, 32'h0FF);
    bus_write(8'h1C, 32'hFFF);
    set_pins(12'h123);
    step(1);
    read_check(8'h00, 32'h0, "R5 one edge not yet visible");
    step(1);
    read_check(8'h00, 32'h023, "R5 level gated by enable");
    step(1);
    read_check(8'h1C, 32'h123, "R6 rise pending");
    bus_write(8'h1C, 32'h003);
    read_check(8'h1C, 32'h120, "R8 partial clear");

    bus_write(8'h24, 32'hFFF);
    set_pins(12'h100);
    step(3);
    read_check(8'h24, 32'h023, "R6 fall pending");

    // R10 per-pin lines
    bus_write(8'h18, 32'h120);
    check("R10 irq from rise", 32'(irq), 32'h120);
    bus_write(8'h20, 32'h002);
    check("R10 irq rise and fall", 32'(irq), 32'h122);

    // R12 all enables off
    for (int k = 0; k < 4; k++) bus_write(8'(8'h18 + 8 * k), 32'h0);
    check("R12 irq all off", 32'(irq), 32'h0);

    // random stretch checked by the model each cycle
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) set_pins(N'($urandom));
      else if (r < 8) bus_write(8'($urandom_range(0, 17) * 4), $urandom);
      else step(1);
    end
    step(2);
    finish_run();
  end
endmodule